// File: doc/BRIEF.md
# Four-Level Interrupt Priority Arbiter

This block sits between the interrupt flags of eight on-chip sources and an 8-bit processor core. Each source has its own enable bit and a two-bit priority level. A global enable gates all of them. In every cycle the block finds the enabled pending source with the highest level. When several sources share that level, a fixed polling order picks the winner. It then offers the winner to the core as a registered request, together with a 16-bit vector address and a 3-bit source index.

The block keeps one in-service bit per priority level so that handlers can nest. A request can interrupt a running handler only when its level is strictly above every level that is already in service. An acknowledge from the core records the winner's level as in service. A return pulse releases the highest level in service.

Some sources are an OR of several flags. The serial source collects transmit-done, receive-done and SPI-complete. The capture/compare array source collects an overflow flag and NCMP match flags. Timer 2 collects its overflow flag and its external flag. A combinational wake-up output lets only the two external interrupt lines bring the device out of power-down, so it works while the clock is stopped.

Top module: `intc_prio_arb`

## Requirements
- R1: Source indices follow the polling order, from first to last: 0 ext0, 1 brownout, 2 timer 0, 3 ext1, 4 timer 1, 5 capture/compare array, 6 serial, 7 timer 2. Among candidates at the same level, the lowest index wins.
- R2: `vector` equals the entry for `src_idx`. The entries for indices 0 to 7 are 0003h, 004Bh, 000Bh, 0013h, 001Bh, 0033h, 0023h and 002Bh.
- R3: When `glb_en` is 0 in a cycle, `irq` is 0 in the next cycle.
- R4: A source whose `src_en` bit is 0 is never selected.
- R5: The level of source i is {`prio_hi[i]`, `prio_lo[i]`}, where 3 is the highest. A candidate at a higher level wins regardless of polling order.
- R6: A candidate is offered only when its level is strictly greater than every level in service. A candidate at an equal or lower level keeps `irq` at 0.
- R7: Outputs are registered. `irq`, `vector` and `src_idx` reflect the inputs one clock later. An `ack` while `irq` is 1 sets the in-service bit of the winner's level and drops `irq` in the next cycle. After that, `vector` and `src_idx` hold their values until `irq` rises again.
- R8: A `reti` pulse clears the highest set in-service bit. When `reti` and an accepted `ack` fall in the same cycle, the clear is applied before the set.
- R9: The serial source is pending when any of `ser_tx_done`, `ser_rx_done` or `spi_done` is 1. The array source is pending on `cca_ovf` or any bit of `cca_match`. The timer 2 source is pending on `tmr2_ovf` or `tmr2_ext`.
- R10: `wake` = (`ext0_req` AND `src_en[0]`) OR (`ext1_req` AND `src_en[3]`). It is combinational and independent of `glb_en`, of levels and of all other sources.
- R11: After reset, `irq` is 0, `vector` and `src_idx` are 0, and no level is in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext0_req | input | 1 | External interrupt 0 flag |
| brown_req | input | 1 | Brownout flag |
| tmr0_ovf | input | 1 | Timer 0 overflow flag |
| ext1_req | input | 1 | External interrupt 1 flag |
| tmr1_ovf | input | 1 | Timer 1 overflow flag |
| cca_ovf | input | 1 | Capture/compare array counter overflow flag |
| cca_match | input | NCMP | Capture/compare array match flags |
| ser_tx_done | input | 1 | Serial transmit-done flag |
| ser_rx_done | input | 1 | Serial receive-done flag |
| spi_done | input | 1 | SPI transfer-complete flag |
| tmr2_ovf | input | 1 | Timer 2 overflow flag |
| tmr2_ext | input | 1 | Timer 2 external flag |
| src_en | input | 8 | Per-source enable, indexed by polling order |
| glb_en | input | 1 | Global enable |
| prio_lo | input | 8 | Low bit of each source's level |
| prio_hi | input | 8 | High bit of each source's level |
| ack | input | 1 | Core accepts the offered interrupt |
| reti | input | 1 | Handler return pulse |
| irq | output | 1 | Registered request to the core |
| vector | output | 16 | Vector address of the offered source |
| src_idx | output | 3 | Index of the offered source |
| wake | output | 1 | Combinational power-down wake-up |

## Verification
The first sweep applies all 256 pending masks under three level settings: all sources equal, a mixed split and a reversed split. The equal setting isolates the polling order. The mixed settings show that level outranks order. A second sweep holds every source pending and runs through all 256 enable masks, which shows that a disabled source cannot win. Each alternate flag of the shared sources is raised on its own, and the global enable is cleared with everything pending. A nesting scenario covers several cases: a blocked request at an equal level, preemption by a higher level, vector hold after an acknowledge, and two returns that release levels from the top down. The wake path is swept over both external lines and their enables while every other input is active and the global enable is off.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int NSRC = 8;
    localparam int IDXW = $clog2(NSRC);
    localparam int LVLW = 2;
    localparam int NLVL = 1 << LVLW;
    localparam int VECW = 16;

    // source positions in polling order
    localparam int SRC_EXT0 = 0;
    localparam int SRC_EXT1 = 3;

    function automatic logic [VECW-1:0] vec_of(input logic [IDXW-1:0] idx);
        logic [VECW-1:0] v;
        case (idx)
            3'd0:    v = 16'h0003;
            3'd1:    v = 16'h004B;
            3'd2:    v = 16'h000B;
            3'd3:    v = 16'h0013;
            3'd4:    v = 16'h001B;
            3'd5:    v = 16'h0033;
            3'd6:    v = 16'h0023;
            default: v = 16'h002B;
        endcase
        return v;
    endfunction

    typedef struct packed {
        logic            irq;
        logic [VECW-1:0] vec;
        logic [IDXW-1:0] idx;
        logic [LVLW-1:0] lvl;
        logic [NLVL-1:0] isr;
    } arb_state_t;
endpackage

// File: rtl/intc_pend_map.sv
module intc_pend_map
    import intc_pkg::*;
#(
    parameter int NCMP = 5
) (
    input  logic            ext0_req,
    input  logic            brown_req,
    input  logic            tmr0_ovf,
    input  logic            ext1_req,
    input  logic            tmr1_ovf,
    input  logic            cca_ovf,
    input  logic [NCMP-1:0] cca_match,
    input  logic            ser_tx_done,
    input  logic            ser_rx_done,
    input  logic            spi_done,
    input  logic            tmr2_ovf,
    input  logic            tmr2_ext,
    output logic [NSRC-1:0] pend
);
    always_comb begin
        pend    = '0;
        pend[0] = ext0_req;
        pend[1] = brown_req;
        pend[2] = tmr0_ovf;
        pend[3] = ext1_req;
        pend[4] = tmr1_ovf;
        pend[5] = cca_ovf | (|cca_match);
        pend[6] = ser_tx_done | ser_rx_done | spi_done;
        pend[7] = tmr2_ovf | tmr2_ext;
    end
endmodule

// File: rtl/intc_level_pick.sv
module intc_level_pick
    import intc_pkg::*;
(
    input  logic [NSRC-1:0] cand,
    input  logic [NSRC-1:0] prio_lo,
    input  logic [NSRC-1:0] prio_hi,
    output logic            any,
    output logic [LVLW-1:0] lvl,
    output logic [IDXW-1:0] idx
);
    logic [NSRC-1:0] at_lvl [NLVL];

    for (genvar g = 0; g < NLVL; g++) begin : g_lvl
        always_comb begin
            for (int i = 0; i < NSRC; i++) begin
                at_lvl[g][i] = cand[i] && ({prio_hi[i], prio_lo[i]} == LVLW'(g));
            end
        end
    end

    always_comb begin
        any = 1'b0;
        lvl = '0;
        idx = '0;
        for (int l = NLVL - 1; l >= 0; l--) begin
            if (!any && (|at_lvl[l])) begin
                any = 1'b1;
                lvl = LVLW'(l);
                for (int i = NSRC - 1; i >= 0; i--) begin
                    if (at_lvl[l][i]) idx = IDXW'(i);
                end
            end
        end
    end
endmodule

// File: rtl/intc_prio_arb.sv
module intc_prio_arb
    import intc_pkg::*;
#(
    parameter int NCMP = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ext0_req,
    input  logic            brown_req,
    input  logic            tmr0_ovf,
    input  logic            ext1_req,
    input  logic            tmr1_ovf,
    input  logic            cca_ovf,
    input  logic [NCMP-1:0] cca_match,
    input  logic            ser_tx_done,
    input  logic            ser_rx_done,
    input  logic            spi_done,
    input  logic            tmr2_ovf,
    input  logic            tmr2_ext,
    input  logic [7:0]      src_en,
    input  logic            glb_en,
    input  logic [7:0]      prio_lo,
    input  logic [7:0]      prio_hi,
    input  logic            ack,
    input  logic            reti,
    output logic            irq,
    output logic [15:0]     vector,
    output logic [2:0]      src_idx,
    output logic            wake
);
    arb_state_t      st_d, st_q;
    logic [NSRC-1:0] pend;
    logic [NSRC-1:0] cand;
    logic            win_any;
    logic [LVLW-1:0] win_lvl;
    logic [IDXW-1:0] win_idx;
    logic            top_valid;
    logic [LVLW-1:0] top_lvl;
    logic            elig;
    logic [NLVL-1:0] isr_mon;
    logic [LVLW-1:0] lvl_mon;

    intc_pend_map #(.NCMP(NCMP)) u_pend (
        .ext0_req    (ext0_req),
        .brown_req   (brown_req),
        .tmr0_ovf    (tmr0_ovf),
        .ext1_req    (ext1_req),
        .tmr1_ovf    (tmr1_ovf),
        .cca_ovf     (cca_ovf),
        .cca_match   (cca_match),
        .ser_tx_done (ser_tx_done),
        .ser_rx_done (ser_rx_done),
        .spi_done    (spi_done),
        .tmr2_ovf    (tmr2_ovf),
        .tmr2_ext    (tmr2_ext),
        .pend        (pend)
    );

    assign cand = pend & src_en & {NSRC{glb_en}};

    intc_level_pick u_pick (
        .cand    (cand),
        .prio_lo (prio_lo),
        .prio_hi (prio_hi),
        .any     (win_any),
        .lvl     (win_lvl),
        .idx     (win_idx)
    );

    // highest level currently in service
    always_comb begin
        top_valid = 1'b0;
        top_lvl   = '0;
        for (int l = 0; l < NLVL; l++) begin
            if (st_q.isr[l]) begin
                top_valid = 1'b1;
                top_lvl   = LVLW'(l);
            end
        end
    end

    assign elig = win_any && (!top_valid || (win_lvl > top_lvl));

    always_comb begin
        logic            cleared;
        logic [NLVL-1:0] isr_n;
        st_d    = st_q;
        isr_n   = st_q.isr;
        cleared = 1'b0;
        if (reti) begin
            for (int l = NLVL - 1; l >= 0; l--) begin
                if (!cleared && isr_n[l]) begin
                    isr_n[l] = 1'b0;
                    cleared  = 1'b1;
                end
            end
        end
        if (st_q.irq && ack) begin
            isr_n[st_q.lvl] = 1'b1;
            st_d.irq        = 1'b0;
        end else begin
            st_d.irq = elig;
            if (elig) begin
                st_d.vec = vec_of(win_idx);
                st_d.idx = win_idx;
                st_d.lvl = win_lvl;
            end
        end
        st_d.isr = isr_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq     = st_q.irq;
    assign vector  = st_q.vec;
    assign src_idx = st_q.idx;
    assign isr_mon = st_q.isr;
    assign lvl_mon = st_q.lvl;

    // clock-free wake path: external lines only
    assign wake = (ext0_req & src_en[SRC_EXT0]) | (ext1_req & src_en[SRC_EXT1]);
endmodule

// File: rtl/intc_prio_arb_chk.sv
module intc_prio_arb_chk
    import intc_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            glb_en,
    input logic            ack,
    input logic            reti,
    input logic            ext0_req,
    input logic            ext1_req,
    input logic            irq,
    input logic [15:0]     vector,
    input logic [2:0]      src_idx,
    input logic            wake,
    input logic [NLVL-1:0] isr,
    input logic [LVLW-1:0] cur_lvl
);
    p_glb_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_en |=> !irq);

    p_vec_map_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (vector == vec_of(src_idx)));

    p_ack_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && ack) |=> (!irq && $stable(vector) && $stable(src_idx)));

    p_hold_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && $past(!irq)) |-> ($stable(vector) && $stable(src_idx)));

    p_ack_isr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && ack) |=> isr[$past(cur_lvl)]);

    p_reti_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reti && !(irq && ack) && (isr != '0)) |=>
            ($countones(isr) == $countones($past(isr)) - 1));

    p_wake_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> (ext0_req || ext1_req));
endmodule

bind intc_prio_arb intc_prio_arb_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .glb_en   (glb_en),
    .ack      (ack),
    .reti     (reti),
    .ext0_req (ext0_req),
    .ext1_req (ext1_req),
    .irq      (irq),
    .vector   (vector),
    .src_idx  (src_idx),
    .wake     (wake),
    .isr      (isr_mon),
    .cur_lvl  (lvl_mon)
);

// File: tb/intc_prio_arb_tb.sv
module intc_prio_arb_tb;
    localparam int NCMP = 5;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            ext0_req = 0, brown_req = 0, tmr0_ovf = 0, ext1_req = 0, tmr1_ovf = 0;
    logic            cca_ovf = 0;
    logic [NCMP-1:0] cca_match = '0;
    logic            ser_tx_done = 0, ser_rx_done = 0, spi_done = 0, tmr2_ovf = 0, tmr2_ext = 0;
    logic [7:0]      src_en = 8'hFF;
    logic            glb_en = 1'b1;
    logic [7:0]      prio_lo = '0, prio_hi = '0;
    logic            ack = 0, reti = 0;
    logic            irq, wake;
    logic [15:0]     vector;
    logic [2:0]      src_idx;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    intc_prio_arb #(.NCMP(NCMP)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .ext0_req(ext0_req), .brown_req(brown_req), .tmr0_ovf(tmr0_ovf),
        .ext1_req(ext1_req), .tmr1_ovf(tmr1_ovf), .cca_ovf(cca_ovf),
        .cca_match(cca_match), .ser_tx_done(ser_tx_done), .ser_rx_done(ser_rx_done),
        .spi_done(spi_done), .tmr2_ovf(tmr2_ovf), .tmr2_ext(tmr2_ext),
        .src_en(src_en), .glb_en(glb_en), .prio_lo(prio_lo), .prio_hi(prio_hi),
        .ack(ack), .reti(reti), .irq(irq), .vector(vector), .src_idx(src_idx),
        .wake(wake)
    );

    function automatic logic [15:0] exp_vec(input int i);
        logic [15:0] t [8] = '{16'h0003, 16'h004B, 16'h000B, 16'h0013,
                               16'h001B, 16'h0033, 16'h0023, 16'h002B};
        return t[i];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic drive_src(input logic [7:0] m);
        {tmr2_ovf, ser_tx_done, cca_ovf, tmr1_ovf, ext1_req, tmr0_ovf, brown_req, ext0_req} = m;
        cca_match = '0; ser_rx_done = 0; spi_done = 0; tmr2_ext = 0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        ack = 0; reti = 0;
        #10;
        rst_n = 1'b1;
        #2;
    endtask

    // expected winner: strictly higher level replaces, so earlier index keeps ties
    task automatic model(input logic [7:0] c, input logic [7:0] lo, input logic [7:0] hi,
                         output bit any, output int idx);
        int best;
        any = 0; idx = 0; best = -1;
        for (int i = 0; i < 8; i++) begin
            if (c[i]) begin
                int lv;
                lv = 2 * int'(hi[i]) + int'(lo[i]);
                if (lv > best) begin best = lv; idx = i; any = 1; end
            end
        end
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] los [3] = '{8'h00, 8'hA5, 8'h5A};
        logic [7:0] his [3] = '{8'h00, 8'h3C, 8'hC3};
        bit e_any;
        int e_idx;
        logic [15:0] held_v;
        logic [2:0]  held_i;

        do_reset();
        // R11 reset state
        check("R11 irq", irq, 0);
        check("R11 vector", vector, 0);
        check("R11 idx", src_idx, 0);

        // R1 R2 R5: all masks under three level settings
        for (int p = 0; p < 3; p++) begin
            prio_lo = los[p]; prio_hi = his[p];
            for (int m = 0; m < 256; m++) begin
                drive_src(8'(m));
                step();
                model(8'(m), prio_lo, prio_hi, e_any, e_idx);
                check("R1/R5 irq", irq, e_any);
                if (e_any) begin
                    check("R1 R5 idx", src_idx, e_idx);
                    check("R2 vector", vector, exp_vec(e_idx));
                end
            end
        end

        // R4: all pending, every enable mask
        prio_lo = 8'hA5; prio_hi = 8'h3C;
        drive_src(8'hFF);
        for (int e = 0; e < 256; e++) begin
            src_en = 8'(e);
            step();
            model(8'(e), prio_lo, prio_hi, e_any, e_idx);
            check("R4 irq", irq, e_any);
            if (e_any) check("R4 idx", src_idx, e_idx);
        end
        src_en = 8'hFF;

        // R3: global enable off
        glb_en = 0;
        step();
        check("R3 irq", irq, 0);
        glb_en = 1;
        prio_lo = 0; prio_hi = 0;

        // R9: alternate flags of shared sources
        for (int k = 0; k < NCMP; k++) begin
            drive_src(0); cca_match[k] = 1'b1;
            step();
            check("R9 cca match", {irq, src_idx}, {1'b1, 3'd5});
        end
        drive_src(0); ser_rx_done = 1; step();
        check("R9 rx", {irq, src_idx}, {1'b1, 3'd6});
        drive_src(0); spi_done = 1; step();
        check("R9 spi", {irq, src_idx}, {1'b1, 3'd6});
        drive_src(0); tmr2_ext = 1; step();
        check("R9 t2 ext", {irq, src_idx}, {1'b1, 3'd7});
        drive_src(0); step();
        check("R9 none", irq, 0);

        // R6 R7 R8: nesting
        do_reset();
        prio_lo = 8'b0001_1000; prio_hi = 8'b0000_0001; // ext0 lvl2, ext1 & tmr1 lvl1
        drive_src(8'b0001_0000); // tmr1
        step();
        check("R7 offer", {irq, src_idx}, {1'b1, 3'd4});
        ack = 1; step(); ack = 0;
        check("R7 drop", irq, 0);
        held_v = vector; held_i = src_idx;
        check("R7 hold v", vector, 16'h001B);
        drive_src(8'b0001_1000); // add ext1 at same level
        step();
        check("R6 equal blocked", irq, 0);
        check("R7 hold idx", src_idx, held_i);
        check("R7 hold vec", vector, held_v);
        drive_src(8'b0001_1001); // ext0 at level 2
        step();
        check("R6 preempt", {irq, src_idx}, {1'b1, 3'd0});
        ack = 1; step(); ack = 0;
        check("R7 drop2", irq, 0);
        drive_src(8'b0001_1000);
        step();
        check("R6 lower blocked", irq, 0);
        reti = 1; step(); reti = 0;   // releases level 2
        step();
        check("R8 lvl1 still busy", irq, 0);
        reti = 1; step(); reti = 0;   // releases level 1
        step();
        check("R8 released", {irq, src_idx}, {1'b1, 3'd3});
        check("R8 vec", vector, 16'h0013);

        // R10: wake path, clock-independent, global enable off
        glb_en = 0;
        prio_lo = 8'hFF; prio_hi = 8'hFF;
        for (int w = 0; w < 16; w++) begin
            drive_src(8'hFF);
            ser_rx_done = 1; spi_done = 1; tmr2_ext = 1; cca_match = '1;
            ext0_req = w[0]; ext1_req = w[1];
            src_en = 8'hFF;
            src_en[0] = w[2]; src_en[3] = w[3];
            #1;
            check("R10 wake", wake, (w[0] & w[2]) | (w[1] & w[3]));
            #1;
        end

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule